// File: doc/BRIEF.md
# Flash Embedded-Operation Status Controller

This block models the write-state machine of a NOR-style flash word array. Commands arrive already decoded on a one-cycle strobe: program a word, erase one sector, erase the whole array, or reset. While an operation runs, the read port does not return array data. It returns a status byte copied into all four byte lanes. The status byte carries a data-polling bit, a bit that toggles on each read, a failure bit and an erase-timer bit. Software polls these bits to follow the operation.

Sector erases are collected inside an acceptance window measured in clock cycles. Each further sector-erase command during the window adds its sector and restarts the window at full length. When the window runs out, the erase begins, and from then on every command is ignored until the erase ends. A chip erase has no window and starts at once. A program that tries to turn a 0 bit into a 1 keeps pulsing until the pulse-count limit is reached. It then reports failure, and only a reset clears the failure. The array is a small behavioural register file that comes out of reset fully erased.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset, `rdData` is 0 and every word reads 32'hFFFFFFFF. When idle, `rdData` shows the word at `rdAddr` one cycle after `rdEn`.
- R2: `cmdOp` 2'b00 programs a word. If `cmdData` sets no bit that is 0 in the stored word, the word becomes `cmdData & old` after `PGM_PULSES` cycles. Status reads during a program return the complement of `cmdData[7]` in status bit 7.
- R3: `cmdOp` 2'b01 opens a sector-erase window of `WINDOW_CYC` cycles, in which status bit 3 reads 0. The sector is `cmdAddr` divided by `SECTOR_WORDS`. Each further sector erase in the window, including one in its last cycle, adds its sector and restarts the window at full length.
- R4: When the window expires, status bit 3 reads 1 and bit 7 reads 0. After `ERASE_CYC` cycles every word of the selected sectors reads all ones, and all other words are unchanged.
- R5: `cmdOp` 2'b10 (chip erase) skips the window. The first status read after it already shows bit 3 = 1, and the whole array ends as all ones.
- R6: While an erase is running, every command is ignored, reset included.
- R7: `cmdOp` 2'b11 (reset) given during the acceptance window cancels the pending erase. No word changes.
- R8: Status bit 6 takes the opposite value on each successive status read.
- R9: A program that would set a 0 bit to 1 fails once `PULSE_LIMIT` pulses have passed. Status bit 5 then reads 1, and the word is unchanged. Bit 5 reads 0 in every other busy state.
- R10: After a failure, status is returned for every read and commands other than reset are ignored. A reset returns the block to array reads.
- R11: A status word is the same byte in all four lanes. The byte is {b7, b6, b5, 0, b3, 0, 0, 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdOp | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reset |
| cmdAddr | input | ADDR_W (4) | Word address of a program, or any address in the sector to erase |
| cmdData | input | 32 | Program data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W (4) | Read word address |
| rdData | output | 32 | Array word or replicated status, registered |

## Verification
Two events can fall in the same cycle: the acceptance window expiring, and a new sector erase arriving. The bench counts cycles from the first sector erase and lands the second command exactly in the window's final cycle. In that collision the command must win. The bench confirms this in two ways. Timer-bit reads taken just before and just after the moment of the restarted expiry must show bit 3 still 0 and then 1. After the erase, both sectors must read all ones, while a program issued during the erase must have left its target word unchanged.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_SECT  = 2'b01,
    OP_CHIP  = 2'b10,
    OP_RESET = 2'b11
  } cmd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_WIN   = 3'd2,
    ST_ERASE = 3'd3,
    ST_FAIL  = 3'd4
  } ctl_state_e;

  typedef struct packed {
    logic       progWrite;
    logic       eraseWrite;
    logic       showStatus;
    logic [7:0] statusByte;
  } ctl_strobe_t;

endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int OFF_W       = 2,
  parameter int SECTORS     = 4,
  parameter int WINDOW_CYC  = 16,
  parameter int ERASE_CYC   = 12,
  parameter int PGM_PULSES  = 3,
  parameter int PULSE_LIMIT = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [31:0]        cmdData,
  input  logic               rdEn,
  input  logic [31:0]        oldWord,
  output ctl_strobe_t        ctl,
  output logic [ADDR_W-1:0]  pgmAddr,
  output logic [31:0]        pgmData,
  output logic [SECTORS-1:0] sectMask,
  output ctl_state_e         state
);

  localparam int MAX_A = (WINDOW_CYC > ERASE_CYC) ? WINDOW_CYC : ERASE_CYC;
  localparam int MAX_B = (PULSE_LIMIT > PGM_PULSES) ? PULSE_LIMIT : PGM_PULSES;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic [CNT_W-1:0]   cnt;
  logic               toggleQ;
  logic               badProgram;
  logic               isSect;
  logic               isReset;
  logic [SECTORS-1:0] cmdSectBit;

  assign badProgram = |(pgmData & ~oldWord);
  assign isSect     = cmdValid && (cmdOp == OP_SECT);
  assign isReset    = cmdValid && (cmdOp == OP_RESET);
  assign cmdSectBit = SECTORS'(1) << cmdAddr[ADDR_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pgmAddr  <= '0;
      pgmData  <= '0;
      sectMask <= '0;
      toggleQ  <= 1'b0;
    end else begin
      if (rdEn && state != ST_IDLE) toggleQ <= ~toggleQ;
      case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            case (cmdOp)
              OP_PROG: begin
                pgmAddr <= cmdAddr;
                pgmData <= cmdData;
                cnt     <= '0;
                state   <= ST_PROG;
              end
              OP_SECT: begin
                sectMask <= cmdSectBit;
                cnt      <= CNT_W'(WINDOW_CYC - 1);
                state    <= ST_WIN;
              end
              OP_CHIP: begin
                sectMask <= '1;
                cnt      <= CNT_W'(ERASE_CYC - 1);
                state    <= ST_ERASE;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_PROG: begin
          if (badProgram) begin
            if (cnt == CNT_W'(PULSE_LIMIT - 1)) state <= ST_FAIL;
            else cnt <= cnt + 1'b1;
          end else if (cnt == CNT_W'(PGM_PULSES - 1)) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WIN: begin
          if (isSect) begin
            sectMask <= sectMask | cmdSectBit;
            cnt      <= CNT_W'(WINDOW_CYC - 1);
          end else if (isReset) begin
            state <= ST_IDLE;
          end else if (cnt == '0) begin
            cnt   <= CNT_W'(ERASE_CYC - 1);
            state <= ST_ERASE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ERASE: begin
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_FAIL: begin
          if (isReset) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic pollBit;
  assign pollBit = (state == ST_PROG || state == ST_FAIL) ? ~pgmData[7] : 1'b0;

  always_comb begin
    ctl.progWrite  = (state == ST_PROG) && !badProgram && (cnt == CNT_W'(PGM_PULSES - 1));
    ctl.eraseWrite = (state == ST_ERASE) && (cnt == '0);
    ctl.showStatus = (state != ST_IDLE);
    ctl.statusByte = {pollBit, toggleQ, (state == ST_FAIL), 1'b0,
                      (state == ST_ERASE), 3'b000};
  end

endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import flash_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int SECTOR_WORDS = 4,
  parameter int SECTORS      = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_strobe_t        ctl,
  input  logic [ADDR_W-1:0]  pgmAddr,
  input  logic [31:0]        pgmData,
  input  logic [SECTORS-1:0] sectMask,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [31:0]        oldWord,
  output logic [31:0]        rdData
);

  localparam int WORDS = SECTOR_WORDS * SECTORS;
  localparam int LANES = 4;

  logic [31:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int SEC = w / SECTOR_WORDS;
    logic [31:0] wordQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wordQ <= '1;
      end else if (ctl.eraseWrite && sectMask[SEC]) begin
        wordQ <= '1;
      end else if (ctl.progWrite && pgmAddr == ADDR_W'(w)) begin
        wordQ <= wordQ & pgmData;
      end
    end
    assign mem[w] = wordQ;
  end

  assign oldWord = mem[pgmAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      rdData <= ctl.showStatus ? {LANES{ctl.statusByte}} : mem[rdAddr];
    end
  end

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_pkg::*;
#(
  parameter int SECTOR_WORDS = 4,
  parameter int SECTORS      = 4,
  parameter int WINDOW_CYC   = 16,
  parameter int ERASE_CYC    = 12,
  parameter int PGM_PULSES   = 3,
  parameter int PULSE_LIMIT  = 6,
  localparam int WORDS       = SECTOR_WORDS * SECTORS,
  localparam int OFF_W       = $clog2(SECTOR_WORDS),
  localparam int ADDR_W      = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [31:0]       cmdData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData
);

  ctl_strobe_t        ctl;
  logic [ADDR_W-1:0]  pgmAddr;
  logic [31:0]        pgmData;
  logic [SECTORS-1:0] sectMask;
  logic [31:0]        oldWord;
  ctl_state_e         state;

  fsc_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SECTORS(SECTORS),
    .WINDOW_CYC(WINDOW_CYC), .ERASE_CYC(ERASE_CYC),
    .PGM_PULSES(PGM_PULSES), .PULSE_LIMIT(PULSE_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rdEn(rdEn), .oldWord(oldWord),
    .ctl(ctl), .pgmAddr(pgmAddr), .pgmData(pgmData), .sectMask(sectMask),
    .state(state)
  );

  fsc_datapath #(
    .ADDR_W(ADDR_W), .SECTOR_WORDS(SECTOR_WORDS), .SECTORS(SECTORS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pgmAddr(pgmAddr), .pgmData(pgmData),
    .sectMask(sectMask), .rdEn(rdEn), .rdAddr(rdAddr), .oldWord(oldWord),
    .rdData(rdData)
  );

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
  import flash_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [1:0]  cmdOp,
  input logic        rdEn,
  input logic [31:0] rdData,
  input ctl_state_e  state
);

  logic busy;
  assign busy = (state != ST_IDLE);

  AST_CHIP_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdValid && cmdOp == OP_CHIP) |=> (state == ST_ERASE)); // R5

  AST_WIN_TIMER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && state == ST_WIN) |=> (rdData[3] == 1'b0)); // R3

  AST_ERASE_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && state == ST_ERASE) |=> (rdData[3] && !rdData[7] && !rdData[5])); // R4

  AST_ERASE_DEAF: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && cmdValid) |=> (state == ST_ERASE || state == ST_IDLE)); // R6

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busy && $past(rdEn && busy)) |=> (rdData[6] != $past(rdData[6]))); // R8

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAIL && !(cmdValid && cmdOp == OP_RESET)) |=> (state == ST_FAIL)); // R10

  AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busy) |=> (rdData[31:24] == rdData[7:0] && rdData[23:16] == rdData[7:0]
                        && rdData[15:8] == rdData[7:0] && rdData[4] == 1'b0
                        && rdData[2:0] == 3'b000)); // R11

endmodule

bind flash_status_ctrl fsc_checker u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .rdEn(rdEn), .rdData(rdData), .state(state)
);

// File: tb/tb_flash_status_ctrl.sv
module tb_flash_status_ctrl;

  localparam int SW = 4;
  localparam int NS = 4;
  localparam int WIN = 16;
  localparam int ERC = 12;
  localparam int WORDS = SW * NS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'b00;
  logic [3:0]  cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic        rdEn = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;

  int  errors = 0;
  int  checks = 0;
  bit  togModel = 1'b0;
  bit  done = 1'b0;
  logic [31:0] got;
  logic [31:0] prevSt;

  always #4 clk = ~clk;

  flash_status_ctrl #(
    .SECTOR_WORDS(SW), .SECTORS(NS), .WINDOW_CYC(WIN), .ERASE_CYC(ERC),
    .PGM_PULSES(3), .PULSE_LIMIT(6)
  ) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData)
  );

  function automatic logic [31:0] pat(int w);
    return 32'h0F0F_00FF ^ (32'(w) * 32'h9E37_79B1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [1:0] op, int addr, logic [31:0] data);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = 4'(addr); cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] v);
    rdEn = 1'b1; rdAddr = 4'(addr);
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic rdStatus(string req, logic b7, logic b5, logic b3);
    logic [31:0] v;
    logic [7:0]  b;
    b = {b7, togModel, b5, 1'b0, b3, 3'b000};
    togModel = ~togModel;
    rd(0, v);
    prevSt = v;
    chk(req, v, {4{b}});
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    chk("R1 reset rdData", rdData, 32'h0);
    for (int w = 0; w < WORDS; w++) begin
      rd(w, got);
      chk("R1 erased after reset", got, 32'hFFFF_FFFF);
    end

    // program sweep over every word
    for (int w = 0; w < WORDS; w++) begin
      cmd(2'b00, w, pat(w));
      rdStatus("R2 poll bit during program", ~pat(w)[7], 1'b0, 1'b0);
      waitCyc(6);
      rd(w, got);
      chk("R2 programmed word", got, pat(w));
    end

    // sector erase window with restart colliding with expiry
    cmd(2'b01, 4, 32'h0);
    waitCyc(WIN - 1);
    cmd(2'b01, 9, 32'h0);
    waitCyc(WIN - 3);
    rdStatus("R3 window restarted bit3 low", 1'b0, 1'b0, 1'b0);
    rdStatus("R3 window bit3 low", 1'b0, 1'b0, 1'b0);
    rdStatus("R3 window last cycle bit3 low", 1'b0, 1'b0, 1'b0);
    got = prevSt;
    rdStatus("R4 erase started bit3 high", 1'b0, 1'b0, 1'b1);
    chk("R8 toggle flips", {31'h0, prevSt[6]}, {31'h0, ~got[6]});
    cmd(2'b00, 0, 32'h0);
    rdStatus("R11 erase status lanes", 1'b0, 1'b0, 1'b1);
    waitCyc(16);
    for (int w = 0; w < WORDS; w++) begin
      rd(w, got);
      if (w >= 4 && w < 12) chk("R4 selected sector erased", got, 32'hFFFF_FFFF);
      else if (w == 0) chk("R6 program ignored during erase", got, pat(0));
      else chk("R4 other sector kept", got, pat(w));
    end

    // reset cancels pending window
    cmd(2'b01, 13, 32'h0);
    rdStatus("R3 window opened", 1'b0, 1'b0, 1'b0);
    waitCyc(2);
    cmd(2'b11, 0, 32'h0);
    waitCyc(WIN + ERC + 4);
    for (int w = 12; w < 16; w++) begin
      rd(w, got);
      chk("R7 reset cancels erase", got, pat(w));
    end

    // chip erase: no window; reset during erase ignored
    cmd(2'b10, 0, 32'h0);
    rdStatus("R5 chip erase immediate", 1'b0, 1'b0, 1'b1);
    cmd(2'b11, 0, 32'h0);
    rdStatus("R6 reset ignored during erase", 1'b0, 1'b0, 1'b1);
    waitCyc(16);
    for (int w = 0; w < WORDS; w++) begin
      rd(w, got);
      chk("R5 chip erased", got, 32'hFFFF_FFFF);
    end

    // program with AND of old data
    cmd(2'b00, 6, 32'h1234_5678);
    waitCyc(8);
    cmd(2'b00, 6, 32'h1030_0070);
    waitCyc(8);
    rd(6, got);
    chk("R2 subset reprogram", got, 32'h1030_0070);

    // failure path
    cmd(2'b00, 5, 32'h0);
    rdStatus("R2 complement of bit7 zero", 1'b1, 1'b0, 1'b0);
    waitCyc(8);
    rd(5, got);
    chk("R2 program zero", got, 32'h0);
    cmd(2'b00, 5, 32'h0000_0080);
    rdStatus("R9 bit5 low before limit", 1'b0, 1'b0, 1'b0);
    waitCyc(8);
    rdStatus("R9 bit5 set at limit", 1'b0, 1'b1, 1'b0);
    cmd(2'b01, 5, 32'h0);
    rdStatus("R10 fail sticky", 1'b0, 1'b1, 1'b0);
    cmd(2'b11, 0, 32'h0);
    rd(5, got);
    chk("R9 failed word unchanged", got, 32'h0);
    rd(4, got);
    chk("R10 array reads after reset", got, 32'hFFFF_FFFF);

    finishRun();
  end

endmodule